// File: doc/BRIEF.md
# SPI Configuration Load Sequencer

This block sits on the host side of a board link to an SRAM-based bridge device that has no non-volatile storage of its own. After each power-up the device has to be configured again. When `start` is pulsed, the block takes chip select low and then turns on both supply enables, so the device sees its select line low while it powers up and chooses SPI slave mode. It waits a fixed settling time and releases chip select. It then acts as an SPI master and streams the configuration image, which arrives one byte at a time on a valid/ready input. After the last byte it sends a burst of dummy clocks.

Once the load is complete, the block waits for the device's configuration-done input. The device reset stays asserted through the whole load. When done is seen, the block enables the reference clock first and releases the device reset one cycle later. If done does not arrive within a timeout, the block records a sticky error and powers the device down again. While the device is running, a loss of PLL lock makes the block pulse the device reset so the PLL can lock again.

All waits are cycle counts derived from the system clock frequency. The SPI clock half period is a parameter, and elaboration rejects any value that would exceed the device's load-clock limit.

Top module: `cfgload_seq`

## Requirements
- R1: After system reset, the outputs are in their idle values: device reset asserted (`dev_rst_n`=0), `spi_cs_n`=1, `spi_sclk`=0, `spi_mosi`=0, both power enables 0, `refclk_en`=0, `s_ready`=0, `load_ok`=0 and `load_err`=0.
- R2: A `start` pulse in idle drives `spi_cs_n` low in the first cycle. Both power enables rise together one cycle later, and they never rise while chip select is high.
- R3: Chip select is released exactly POWER_US*CLK_MHZ cycles after the power enables rise. No SPI clock edge occurs before that point.
- R4: Data bytes are sent MSB first in SPI mode 0 with `spi_cs_n` low. The clock idles low and `spi_mosi` changes only while the clock is low. Bit periods within a byte are 2*SCLK_HALF cycles. Elaboration rejects a setting where CLK_MHZ exceeds 50*SCLK_HALF, which would mean an SPI clock above 25 MHz.
- R5: `s_ready` is high only during the data phase, with chip select low, while no byte is shifting and before the byte flagged by `s_last` has been taken. Each accepted handshake sends exactly one byte, in order.
- R6: After the last byte, exactly DUMMY_CLKS further clock rising edges are issued (49 by default), with `spi_cs_n` high and `spi_mosi` low.
- R7: The device reset stays asserted from `start` until configuration-done is seen, including every SPI clock edge.
- R8: SYNC_STAGES+1 cycles after `cfg_done_in` rises in the done wait, `refclk_en` and `load_ok` go high. `dev_rst_n` rises one cycle after that.
- R9: If done is not seen within TIMEOUT_US*CLK_MHZ cycles after the dummy clocks, `load_err` is set and the outputs return to idle. `load_err` stays set until the next `start` clears it, and it never coincides with `load_ok` or with the power enables.
- R10: While running, a low on `pll_locked` pulls `dev_rst_n` low SYNC_STAGES+1 cycles later for exactly RESYNC_CYC cycles. `refclk_en` stays high throughout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low system reset |
| start | input | 1 | Begin a configuration load (taken in idle only) |
| s_data | input | 8 | Configuration byte |
| s_valid | input | 1 | Configuration byte valid |
| s_last | input | 1 | Marks the final configuration byte |
| s_ready | output | 1 | Byte accepted when high together with s_valid |
| cfg_done_in | input | 1 | Device configuration-done pin (asynchronous) |
| pll_locked | input | 1 | Device PLL lock status (asynchronous) |
| dev_rst_n | output | 1 | Device reset, active low |
| spi_cs_n | output | 1 | SPI chip select, active low |
| spi_sclk | output | 1 | SPI clock |
| spi_mosi | output | 1 | SPI data to device |
| pwr_io_en | output | 1 | SPI-side supply enable |
| pwr_core_en | output | 1 | Core supply enable |
| refclk_en | output | 1 | Reference clock enable |
| load_ok | output | 1 | Configuration completed |
| load_err | output | 1 | Sticky done-timeout error |

## Verification
Inputs are driven and outputs sampled on falling clock edges. Each result is expected at a fixed count of rising edges after its stimulus. Chip select falls in the first cycle after `start`, and the power enables follow in the next. The bench counts exactly POWER_US*CLK_MHZ samples with power on and chip select low. For `cfg_done_in` and `pll_locked`, the synchroniser delay means the reference clock and `load_ok` appear at the SYNC_STAGES+1th sample and the device reset release at the next one. Reset is seen low at that same offset after a lock drop and stays low for exactly RESYNC_CYC samples. A monitor rebuilds each byte from the rising SPI clock edges, checks the bit spacing, and pops the byte the driver queued. It also counts the dummy edges.

// File: rtl/cfgload_pkg.sv
package cfgload_pkg;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_CSLOW,
      ST_PWRWAIT,
      ST_CSREL,
      ST_DATA,
      ST_DUMMY,
      ST_WAITDONE,
      ST_REFON,
      ST_RUN,
      ST_RESYNC
   } seq_state_t;

   function automatic int unsigned imax(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/cfgload_sync.sv
module cfgload_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("cfgload_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[STAGES-2:0], d};
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/cfgload_timer.sv
module cfgload_timer #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] value,
   output logic         zero
);
   logic [W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          cnt <= '0;
      else if (load)       cnt <= value;
      else if (cnt != '0)  cnt <= cnt - W'(1);
   end

   assign zero = (cnt == '0);
endmodule

// File: rtl/cfgload_spi_tx.sv
module cfgload_spi_tx #(
   parameter int HALF  = 5,
   parameter int CNT_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             go,
   input  logic [7:0]       data,
   input  logic [CNT_W-1:0] nclk,
   output logic             busy,
   output logic             sclk,
   output logic             mosi
);
   localparam int DIV_W = (HALF > 1) ? $clog2(HALF) : 1;

   if (HALF < 1) begin : g_bad_half
      $error("cfgload_spi_tx: HALF must be at least 1");
   end

   logic [DIV_W-1:0] div;
   logic [CNT_W-1:0] left;
   logic [7:0]       sh;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy <= 1'b0;
         sclk <= 1'b0;
         div  <= '0;
         left <= '0;
         sh   <= '0;
      end else if (go && !busy) begin
         sh   <= data;
         left <= nclk;
         busy <= (nclk != '0);
         sclk <= 1'b0;
         div  <= '0;
      end else if (busy) begin
         if (div == DIV_W'(HALF - 1)) begin
            div <= '0;
            if (!sclk) begin
               sclk <= 1'b1;
            end else begin
               sclk <= 1'b0;
               sh   <= {sh[6:0], 1'b0};
               left <= left - CNT_W'(1);
               if (left == CNT_W'(1)) busy <= 1'b0;
            end
         end else begin
            div <= div + DIV_W'(1);
         end
      end
   end

   assign mosi = busy & sh[7];
endmodule

// File: rtl/cfgload_seq.sv
module cfgload_seq
   import cfgload_pkg::*;
#(
   parameter int CLK_MHZ     = 250,
   parameter int SCLK_HALF   = 5,
   parameter int POWER_US    = 50,
   parameter int TIMEOUT_US  = 100,
   parameter int DUMMY_CLKS  = 49,
   parameter int RESYNC_CYC  = 32,
   parameter int SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       start,
   input  logic [7:0] s_data,
   input  logic       s_valid,
   input  logic       s_last,
   output logic       s_ready,
   input  logic       cfg_done_in,
   input  logic       pll_locked,
   output logic       dev_rst_n,
   output logic       spi_cs_n,
   output logic       spi_sclk,
   output logic       spi_mosi,
   output logic       pwr_io_en,
   output logic       pwr_core_en,
   output logic       refclk_en,
   output logic       load_ok,
   output logic       load_err
);
   localparam int PWR_CYC = POWER_US * CLK_MHZ;
   localparam int TMO_CYC = TIMEOUT_US * CLK_MHZ;
   localparam int TMR_MAX = imax(imax(PWR_CYC, TMO_CYC), RESYNC_CYC);
   localparam int TMR_W   = $clog2(TMR_MAX + 1);
   localparam int CNT_W   = $clog2(imax(DUMMY_CLKS, 8) + 1);

   if (CLK_MHZ > 50 * SCLK_HALF) begin : g_bad_sclk
      $error("cfgload_seq: SPI clock would exceed 25 MHz");
   end
   if (POWER_US < 1 || TIMEOUT_US < 1 || RESYNC_CYC < 1 || DUMMY_CLKS < 1) begin : g_bad_wait
      $error("cfgload_seq: waits and dummy count must be non-zero");
   end

   seq_state_t state, state_n;
   logic done_s, lock_s;
   logic tmr_load, tmr_zero;
   logic [TMR_W-1:0] tmr_val;
   logic tx_go, tx_busy;
   logic [7:0] tx_byte;
   logic [CNT_W-1:0] tx_cnt;
   logic last_seen, ok_q, err_q;
   logic accept;

   cfgload_sync #(.STAGES(SYNC_STAGES)) u_sync_done (
      .clk(clk), .rst_n(rst_n), .d(cfg_done_in), .q(done_s));
   cfgload_sync #(.STAGES(SYNC_STAGES)) u_sync_lock (
      .clk(clk), .rst_n(rst_n), .d(pll_locked), .q(lock_s));

   cfgload_timer #(.W(TMR_W)) u_timer (
      .clk(clk), .rst_n(rst_n), .load(tmr_load), .value(tmr_val), .zero(tmr_zero));

   cfgload_spi_tx #(.HALF(SCLK_HALF), .CNT_W(CNT_W)) u_tx (
      .clk(clk), .rst_n(rst_n), .go(tx_go), .data(tx_byte), .nclk(tx_cnt),
      .busy(tx_busy), .sclk(spi_sclk), .mosi(spi_mosi));

   assign s_ready = (state == ST_DATA) && !tx_busy && !last_seen;
   assign accept  = s_valid && s_ready;

   always_comb begin
      state_n  = state;
      tmr_load = 1'b0;
      tmr_val  = '0;
      tx_go    = 1'b0;
      tx_byte  = s_data;
      tx_cnt   = CNT_W'(8);
      case (state)
         ST_IDLE:    if (start) state_n = ST_CSLOW;
         ST_CSLOW: begin
            state_n  = ST_PWRWAIT;
            tmr_load = 1'b1;
            tmr_val  = TMR_W'(PWR_CYC - 1);
         end
         ST_PWRWAIT: if (tmr_zero) state_n = ST_CSREL;
         ST_CSREL:   state_n = ST_DATA;
         ST_DATA: begin
            if (accept) begin
               tx_go = 1'b1;
            end else if (last_seen && !tx_busy) begin
               tx_go   = 1'b1;
               tx_byte = 8'h00;
               tx_cnt  = CNT_W'(DUMMY_CLKS);
               state_n = ST_DUMMY;
            end
         end
         ST_DUMMY: begin
            if (!tx_busy) begin
               state_n  = ST_WAITDONE;
               tmr_load = 1'b1;
               tmr_val  = TMR_W'(TMO_CYC - 1);
            end
         end
         ST_WAITDONE: begin
            if (done_s)        state_n = ST_REFON;
            else if (tmr_zero) state_n = ST_IDLE;
         end
         ST_REFON:   state_n = ST_RUN;
         ST_RUN: begin
            if (!lock_s) begin
               state_n  = ST_RESYNC;
               tmr_load = 1'b1;
               tmr_val  = TMR_W'(RESYNC_CYC - 1);
            end
         end
         ST_RESYNC:  if (tmr_zero) state_n = ST_RUN;
         default:    state_n = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         last_seen <= 1'b0;
         ok_q      <= 1'b0;
         err_q     <= 1'b0;
      end else begin
         state <= state_n;
         if (state == ST_IDLE && start) begin
            last_seen <= 1'b0;
            ok_q      <= 1'b0;
            err_q     <= 1'b0;
         end else begin
            if (accept && s_last) last_seen <= 1'b1;
            if (state == ST_WAITDONE && done_s) ok_q <= 1'b1;
            if (state == ST_WAITDONE && !done_s && tmr_zero) err_q <= 1'b1;
         end
      end
   end

   assign spi_cs_n    = !(state inside {ST_CSLOW, ST_PWRWAIT, ST_DATA});
   assign pwr_core_en = !(state inside {ST_IDLE, ST_CSLOW});
   assign pwr_io_en   = pwr_core_en;
   assign refclk_en   = state inside {ST_REFON, ST_RUN, ST_RESYNC};
   assign dev_rst_n   = (state == ST_RUN);
   assign load_ok     = ok_q;
   assign load_err    = err_q;
endmodule

// File: rtl/cfgload_seq_chk.sv
module cfgload_seq_chk (
   input logic clk,
   input logic rst_n,
   input logic s_ready,
   input logic dev_rst_n,
   input logic spi_cs_n,
   input logic spi_sclk,
   input logic spi_mosi,
   input logic pwr_io_en,
   input logic pwr_core_en,
   input logic refclk_en,
   input logic load_ok,
   input logic load_err
);
   assert_cs_before_power_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pwr_core_en) |-> !spi_cs_n);
   assert_supplies_together_R2: assert property (@(posedge clk) disable iff (!rst_n)
      pwr_io_en == pwr_core_en);
   assert_sclk_needs_power_R3: assert property (@(posedge clk) disable iff (!rst_n)
      spi_sclk |-> pwr_core_en);
   assert_mosi_stable_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (spi_sclk && $past(spi_sclk)) |-> $stable(spi_mosi));
   assert_ready_in_data_R5: assert property (@(posedge clk) disable iff (!rst_n)
      s_ready |-> (!spi_cs_n && pwr_core_en));
   assert_dummy_mosi_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (spi_sclk && spi_cs_n) |-> !spi_mosi);
   assert_reset_during_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
      spi_sclk |-> !dev_rst_n);
   assert_refclk_first_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(dev_rst_n) |-> $past(refclk_en));
   assert_ok_err_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !(load_ok && load_err));
   assert_err_powered_down_R9: assert property (@(posedge clk) disable iff (!rst_n)
      load_err |-> !pwr_core_en);
   assert_refclk_kept_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(dev_rst_n) |-> refclk_en);
endmodule

bind cfgload_seq cfgload_seq_chk u_chk (
   .clk(clk), .rst_n(rst_n), .s_ready(s_ready), .dev_rst_n(dev_rst_n),
   .spi_cs_n(spi_cs_n), .spi_sclk(spi_sclk), .spi_mosi(spi_mosi),
   .pwr_io_en(pwr_io_en), .pwr_core_en(pwr_core_en), .refclk_en(refclk_en),
   .load_ok(load_ok), .load_err(load_err));

// File: tb/tb_cfgload_seq.sv
module tb_cfgload_seq;
   localparam int CLK_MHZ    = 20;
   localparam int SCLK_HALF  = 2;
   localparam int POWER_US   = 50;
   localparam int TIMEOUT_US = 20;
   localparam int DUMMY      = 49;
   localparam int RESYNC     = 12;
   localparam int SYNC       = 2;
   localparam int PWR_CYC    = POWER_US * CLK_MHZ;
   localparam int TMO_CYC    = TIMEOUT_US * CLK_MHZ;

   logic clk = 1'b0;
   logic rst_n, start, s_valid, s_last, s_ready, cfg_done_in, pll_locked;
   logic [7:0] s_data;
   logic dev_rst_n, spi_cs_n, spi_sclk, spi_mosi, pwr_io_en, pwr_core_en;
   logic refclk_en, load_ok, load_err;

   always #2 clk = ~clk;

   cfgload_seq #(
      .CLK_MHZ(CLK_MHZ), .SCLK_HALF(SCLK_HALF), .POWER_US(POWER_US),
      .TIMEOUT_US(TIMEOUT_US), .DUMMY_CLKS(DUMMY), .RESYNC_CYC(RESYNC),
      .SYNC_STAGES(SYNC)
   ) dut (
      .clk(clk), .rst_n(rst_n), .start(start), .s_data(s_data), .s_valid(s_valid),
      .s_last(s_last), .s_ready(s_ready), .cfg_done_in(cfg_done_in),
      .pll_locked(pll_locked), .dev_rst_n(dev_rst_n), .spi_cs_n(spi_cs_n),
      .spi_sclk(spi_sclk), .spi_mosi(spi_mosi), .pwr_io_en(pwr_io_en),
      .pwr_core_en(pwr_core_en), .refclk_en(refclk_en), .load_ok(load_ok),
      .load_err(load_err));

   int checks = 0;
   int bad = 0;
   bit finished = 0;
   logic [7:0] exp_q[$];

   task automatic chk(input bit cond, input string req, input string what,
                      input int act, input int exp);
      checks++;
      if (!cond) begin
         bad++;
         $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
      end
   endtask

   // monitor: rebuilds bytes from rising SPI clock edges
   int cyc = 0;
   logic prev_sclk = 1'b0;
   int bitcnt = 0;
   logic [7:0] shreg = 8'h00;
   int last_rise = 0;
   int dummy_total = 0;
   int rise_total = 0;

   always @(negedge clk) begin
      cyc++;
      if (rst_n && spi_sclk && !prev_sclk) begin
         rise_total++;
         chk(!dev_rst_n, "R7", "device reset at SPI edge", dev_rst_n, 0);
         if (!spi_cs_n) begin
            if (bitcnt != 0)
               chk(cyc - last_rise == 2 * SCLK_HALF, "R4", "bit period",
                   cyc - last_rise, 2 * SCLK_HALF);
            shreg = {shreg[6:0], spi_mosi};
            bitcnt++;
            if (bitcnt == 8) begin
               bitcnt = 0;
               if (exp_q.size() == 0) begin
                  chk(0, "R5", "unexpected byte", shreg, -1);
               end else begin
                  logic [7:0] e;
                  e = exp_q.pop_front();
                  chk(shreg == e, "R4", "byte MSB first", shreg, e);
               end
            end
         end else begin
            dummy_total++;
            if (spi_mosi) chk(0, "R6", "mosi during dummy", spi_mosi, 0);
         end
         last_rise = cyc;
      end
      if (spi_cs_n) bitcnt = 0;
      prev_sclk = spi_sclk;
   end

   // driver: offer a byte, push the expected value when taken
   task automatic send_byte(input logic [7:0] b, input logic last, input int gap);
      repeat (gap) @(negedge clk);
      s_data  = b;
      s_last  = last;
      s_valid = 1'b1;
      forever begin
         if (s_ready) begin
            exp_q.push_back(b);
            @(negedge clk);
            break;
         end
         @(negedge clk);
      end
      s_valid = 1'b0;
      s_last  = 1'b0;
   endtask

   task automatic sys_reset();
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic pulse_start();
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         bad++;
         checks++;
         $display("FAIL watchdog: run did not complete, got 0 expected 1");
         $display("  test done: total=%0d bad=%0d", checks, bad);
         $finish;
      end
   end

   initial begin
      int n;
      int d0;
      rst_n = 1'b0; start = 1'b0; s_valid = 1'b0; s_last = 1'b0; s_data = 8'h00;
      cfg_done_in = 1'b0; pll_locked = 1'b1;
      sys_reset();

      // R1 idle state
      chk(!dev_rst_n && spi_cs_n && !spi_sclk && !spi_mosi, "R1", "reset pins",
          {dev_rst_n, spi_cs_n, spi_sclk, spi_mosi}, 4'b0100);
      chk(!pwr_io_en && !pwr_core_en && !refclk_en && !s_ready, "R1", "enables/ready",
          {pwr_io_en, pwr_core_en, refclk_en, s_ready}, 0);
      chk(!load_ok && !load_err, "R1", "status", {load_ok, load_err}, 0);

      // ---------- load 1: success ----------
      pulse_start();
      chk(!spi_cs_n && !pwr_core_en, "R2", "cs low before power",
          {spi_cs_n, pwr_core_en}, 0);
      @(negedge clk);
      chk(pwr_io_en && pwr_core_en && !spi_cs_n, "R2", "both supplies on",
          {pwr_io_en, pwr_core_en, spi_cs_n}, 3'b110);
      n = 0;
      while (pwr_core_en && !spi_cs_n) begin
         n++;
         @(negedge clk);
      end
      chk(n == PWR_CYC, "R3", "power-on cycles before cs release", n, PWR_CYC);
      chk(rise_total == 0, "R3", "sclk edges before release", rise_total, 0);

      d0 = dummy_total;
      send_byte(8'hA5, 1'b0, 0);
      send_byte(8'h3C, 1'b0, 3);
      send_byte(8'h01, 1'b0, 0);
      send_byte(8'h80, 1'b0, 5);
      send_byte(8'hFF, 1'b1, 0);
      repeat (8 * 2 * SCLK_HALF + DUMMY * 2 * SCLK_HALF + 30) @(negedge clk);
      chk(dummy_total - d0 == DUMMY, "R6", "dummy clocks", dummy_total - d0, DUMMY);
      chk(exp_q.size() == 0, "R5", "bytes left unsent", exp_q.size(), 0);
      chk(!s_ready, "R5", "ready after last byte", s_ready, 0);
      chk(!dev_rst_n && !refclk_en, "R7", "reset held after load",
          {dev_rst_n, refclk_en}, 0);
      chk(!load_ok && !load_err, "R8", "no status before done", {load_ok, load_err}, 0);

      cfg_done_in = 1'b1;
      repeat (SYNC) @(negedge clk);
      chk(!refclk_en, "R8", "refclk before sync delay", refclk_en, 0);
      @(negedge clk);
      chk(refclk_en && !dev_rst_n && load_ok, "R8", "refclk on, reset held",
          {refclk_en, dev_rst_n, load_ok}, 3'b101);
      @(negedge clk);
      chk(dev_rst_n && refclk_en, "R8", "reset released", {dev_rst_n, refclk_en}, 3);

      // PLL lock drop
      repeat (5) @(negedge clk);
      pll_locked = 1'b0;
      @(negedge clk);
      pll_locked = 1'b1;
      repeat (SYNC - 1) @(negedge clk);
      chk(dev_rst_n, "R10", "reset still released before sync delay", dev_rst_n, 1);
      @(negedge clk);
      n = 0;
      while (!dev_rst_n && n < 10 * RESYNC) begin
         if (!refclk_en) chk(0, "R10", "refclk during resync", refclk_en, 1);
         n++;
         @(negedge clk);
      end
      chk(n == RESYNC, "R10", "resync reset length", n, RESYNC);
      chk(refclk_en && load_ok, "R10", "running after resync", {refclk_en, load_ok}, 3);

      // ---------- load 2: timeout ----------
      cfg_done_in = 1'b0;
      sys_reset();
      pulse_start();
      while (!(pwr_core_en && spi_cs_n)) @(negedge clk);
      d0 = dummy_total;
      send_byte(8'h00, 1'b0, 0);
      send_byte(8'h7E, 1'b1, 2);
      repeat (8 * 2 * SCLK_HALF + DUMMY * 2 * SCLK_HALF + 30) @(negedge clk);
      chk(dummy_total - d0 == DUMMY, "R6", "dummy clocks, second load",
          dummy_total - d0, DUMMY);
      chk(exp_q.size() == 0, "R5", "bytes left, second load", exp_q.size(), 0);
      chk(!load_err && pwr_core_en, "R9", "still waiting for done",
          {load_err, pwr_core_en}, 1);
      repeat (TMO_CYC + 5) @(negedge clk);
      chk(load_err && !load_ok, "R9", "timeout flagged", {load_err, load_ok}, 2);
      chk(!pwr_core_en && !pwr_io_en && spi_cs_n && !refclk_en && !dev_rst_n, "R9",
          "idle after timeout", {pwr_core_en, pwr_io_en, spi_cs_n, refclk_en, dev_rst_n},
          5'b00100);
      repeat (20) @(negedge clk);
      chk(load_err, "R9", "error sticky", load_err, 1);
      pulse_start();
      chk(!load_err && !spi_cs_n, "R9", "start clears error", {load_err, spi_cs_n}, 0);

      finished = 1;
      $display("  test done: total=%0d bad=%0d", checks, bad);
      $finish;
   end
endmodule